// File: doc/BRIEF.md
# Multichannel ADC Readout Sequencer

This block sits between a 16-bit register bus and an eight-channel analog front end. Software selects which channels take part by writing a channel-enable mask. It then launches a conversion by *reading* a start offset. After a fixed latency, every enabled channel latches the value present on its parallel sample input. Channels that are not enabled keep whatever result they held before.

While the conversion runs, a busy flag is raised. When the flag drops, software reads a data window. The window is mirrored over eight consecutive halfword offsets, and every read from it returns the next enabled channel's result in ascending channel order. Disabled channels are skipped. When no enabled channel remains at or above the readout pointer, the stream wraps to channel 0.

Results are 14-bit two's-complement codes spanning the converter's full bipolar range. They are returned sign-extended in a 16-bit word.

Top module: `adc_seq`

## Requirements
- R1: After reset, the mask and all eight results are zero, the readout pointer is at channel 0 and `busy` is low. A data read therefore returns 0x0000.
- R2: A write to offset 0x00 sets the mask from `reg_wdata[7:0]`, where bit i enables channel i. Writes to any other offset, including 0x20, change nothing.
- R3: A read of offset 0x20 returns 0xFFFF, moves the readout pointer to channel 0 and holds `busy` high for exactly `CONV_CYCLES` clock cycles. A start read issued while `busy` is high restarts the full count.
- R4: When `busy` falls, each channel enabled in the mask at that moment holds the sample that was on its input. Each disabled channel keeps its previous result.
- R5: A read at any even offset from 0x00 to 0x0E, made while `busy` is low, returns the result of the lowest enabled channel at or above the pointer. The pointer then moves to one past that channel.
- R6: If no enabled channel lies at or above the pointer, including when the pointer is past channel 7 or the mask is zero, the read returns channel 0's result and the pointer becomes 1.
- R7: A data-window read while `busy` is high returns 0xFFFF and leaves the pointer unchanged.
- R8: Each result is the 14-bit two's-complement sample with bit 13 copied into bits 15:14 of the read word.
- R9: A read of an offset outside the data window and the start offset returns 0x0000 and has no effect on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Byte offset of the access |
| reg_rd | input | 1 | Read strobe, one access per cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of `reg_rd` |
| samples | input | 112 | Channel i sample in bits 14*i+13 : 14*i |
| busy | output | 1 | Conversion in progress |

## Verification
The hardest states to reach are those where the readout pointer and the mask disagree. These include a pointer that has already passed every enabled channel, a pointer left at 8 after channel 7, and a mask widened after a conversion, so that channels with stale retained results reappear in the stream. The stimulus reaches them by reading past the end of the enabled set and by changing the mask between conversions without starting a new one. It also issues a start and a data read inside the busy window, and a second start on top of a running conversion.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int NCH         = 8,
  parameter int SW          = 14,
  parameter int DW          = 16,
  parameter int AW          = 6,
  parameter int CONV_CYCLES = 12,
  parameter logic [AW-1:0] START_OFF = 6'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NCH*SW-1:0] samples,
  output logic              busy
);
  localparam int PW = $clog2(NCH + 1);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [NCH-1:0]   mask;
  logic [SW-1:0]    res [NCH];
  logic [PW-1:0]    ptr, sel;
  logic [CW-1:0]    cnt;
  logic             hit;

  wire win_acc   = (reg_addr[AW-1:1] < (AW-1)'(NCH));
  wire start_rd  = reg_rd && (reg_addr == START_OFF);
  wire data_rd   = reg_rd && win_acc;
  wire mask_wr   = reg_wr && (reg_addr[AW-1:1] == '0);
  wire conv_done = busy && (cnt == '0);

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = 0; i < NCH; i++)
      if (!hit && mask[i] && (PW'(i) >= ptr)) begin
        hit = 1'b1;
        sel = PW'(i);
      end
  end

  wire [SW-1:0] sel_res = res[sel[PW-1:0] < PW'(NCH) ? sel : '0];

  always_comb begin
    if (start_rd || (data_rd && busy)) reg_rdata = '1;
    else if (data_rd)                   reg_rdata = {{(DW-SW){sel_res[SW-1]}}, sel_res};
    else                                reg_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      ptr  <= '0;
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      if (mask_wr) mask <= reg_wdata[NCH-1:0];
      if (start_rd) begin
        busy <= 1'b1;
        cnt  <= CW'(CONV_CYCLES - 1);
        ptr  <= '0;
      end else begin
        if (conv_done)         busy <= 1'b0;
        else if (busy)         cnt  <= cnt - 1'b1;
        if (data_rd && !busy)  ptr  <= sel + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    res[g] <= '0;
      else if (conv_done && mask[g]) res[g] <= samples[g*SW +: SW];
    end

    AST_KEEP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !mask[g]) |=> $stable(res[g])) else $error("disabled channel changed"); // R4
    AST_LOAD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && mask[g]) |=> (res[g] == $past(samples[g*SW +: SW]))) else $error("enabled channel not loaded"); // R4
  end

  AST_START_RESETS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> (busy && ptr == '0)) else $error("start did not arm"); // R3
  AST_START_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |-> (reg_rdata == 16'hFFFF)) else $error("start data"); // R3
  AST_BUSY_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && busy) |=> $stable(ptr)) else $error("pointer moved while busy"); // R7
  AST_BUSY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && busy) |-> (reg_rdata == 16'hFFFF)) else $error("busy data"); // R7
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(NCH)) else $error("pointer out of range"); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !busy && !hit) |=> (ptr == PW'(1))) else $error("wrap pointer"); // R6
  AST_OTHER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !win_acc && !start_rd) |=> $stable(ptr)) else $error("stray read moved pointer"); // R9
endmodule

// File: tb/test_adc_seq.sv
module test_adc_seq;
  localparam int NCH = 8;
  localparam int SW  = 14;
  localparam int LAT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NCH*SW-1:0] samples;
  logic        busy;
  logic [SW-1:0] smp_v [NCH];

  always #4 clk = ~clk;

  for (genvar g = 0; g < NCH; g++) begin : g_s
    assign samples[g*SW +: SW] = smp_v[g];
  end

  adc_seq #(.CONV_CYCLES(LAT)) i_adc_seq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .samples(samples), .busy(busy));

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q [$];
  string tag_q [$];
  event smp_ev;

  logic [15:0] m_res [NCH];
  logic [7:0]  m_mask;
  int          m_ptr;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [15:0] mon_e;
  string mon_t;
  always @(smp_ev) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      check(mon_t, reg_rdata, mon_e);
    end
  end

  function automatic logic [15:0] sx(logic [SW-1:0] v);
    return {{(16-SW){v[SW-1]}}, v};
  endfunction

  task automatic bus_read(logic [5:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    #2 -> smp_ev;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic bus_write(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
    if (a[5:1] == 0) m_mask = d[7:0];
  endtask

  task automatic data_read(logic [5:0] a, string tag);
    int s = -1;
    for (int i = m_ptr; i < NCH; i++)
      if (s < 0 && m_mask[i]) s = i;
    if (s < 0) s = 0;
    m_ptr = s + 1;
    bus_read(a, m_res[s], tag);
  endtask

  task automatic finish_conv();
    for (int i = 0; i < NCH; i++)
      if (m_mask[i]) m_res[i] = sx(smp_v[i]);
  endtask

  task automatic conv(bit probe, bit restart);
    int n = 0;
    bus_read(6'h20, 16'hFFFF, "R3 start data");
    m_ptr = 0;
    if (restart) bus_read(6'h20, 16'hFFFF, "R3 restart data");
    if (probe) bus_read(6'h04, 16'hFFFF, "R7 busy read");
    @(negedge clk);
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    if (!probe) check("R3 busy length", 16'(n), 16'(LAT));
    finish_conv();
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      smp_v[i] = SW'(100 * (i + 1));
      m_res[i] = '0;
    end
    m_mask = '0; m_ptr = 0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", {15'd0, busy}, 16'd0);
    data_read(6'h00, "R1 reset result");

    bus_write(6'h20, 16'h00FF);
    m_mask = '0;
    @(negedge clk);
    check("R2 write to start offset ignored", {15'd0, busy}, 16'd0);

    bus_write(6'h00, 16'h00A6);
    smp_v[0] = 14'h0AAA;
    conv(1'b0, 1'b0);
    data_read(6'h00, "R5 first enabled ch1");
    data_read(6'h02, "R5 ch2");
    data_read(6'h0E, "R5 ch5 mirrored");
    bus_read(6'h30, 16'h0000, "R9 stray read");
    data_read(6'h08, "R5 ch7");
    data_read(6'h06, "R6 wrap to ch0 retained");
    data_read(6'h0A, "R6 after wrap ch1");

    for (int i = 0; i < NCH; i++) smp_v[i] = SW'(16'h0200 + i);
    smp_v[0] = 14'h2001;
    bus_write(6'h00, 16'h0001);
    conv(1'b1, 1'b0);
    data_read(6'h00, "R8 negative ch0");
    data_read(6'h00, "R6 none above pointer");
    bus_write(6'h00, 16'h00FF);
    data_read(6'h04, "R4 ch1 retained");
    data_read(6'h04, "R4 ch2 retained");
    data_read(6'h04, "R4 ch3 never loaded");

    smp_v[3] = 14'h1FFF;
    conv(1'b0, 1'b1);
    data_read(6'h0C, "R3 pointer reset ch0");
    data_read(6'h0C, "R4 ch1 reloaded");
    data_read(6'h0C, "R4 ch2 reloaded");
    data_read(6'h0C, "R8 positive max ch3");
    for (int k = 0; k < 4; k++) data_read(6'h02, "R5 ascending tail");
    data_read(6'h02, "R6 wrap past ch7");

    bus_write(6'h00, 16'h0000);
    data_read(6'h00, "R6 empty mask");

    bus_read(6'h20, 16'hFFFF, "R3 start before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    check("R1 busy cleared by reset", {15'd0, busy}, 16'd0);
    #5 rst_n = 1'b1;
    for (int i = 0; i < NCH; i++) m_res[i] = '0;
    m_mask = '0; m_ptr = 0;
    bus_write(6'h00, 16'h0080);
    data_read(6'h0E, "R1 results cleared");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule